// File: doc/BRIEF.md
# SPI Master Shift Engine with Partial-Byte Receive

This block is a serial peripheral master that moves one transfer at a time under control of a small set of configuration and command inputs. A transfer clocks out a byte most significant bit first and, at the same time, captures the bits returned by the attached device. The number of clocks per transfer comes from a 3-bit length field, so the engine can take a full byte or any count of 1 to 7 bits for serial streams that are not byte aligned. Captured values are right-aligned and placed in a small receive queue that software drains through a read port.

The engine runs in clock mode 0. Its serial clock comes from a divider of the system clock. Slave select is either framed automatically around each transfer, with a programmable guard time on both sides, or held by a manual control bit. A three-wire option treats the data-out and data-in lines as one shared pin. Each transfer then runs in one direction only, and the output enable is released during receive transfers.

A CRC accumulator runs over the serial stream, one bit per rising serial-clock edge. It supports three polynomials and can be cleared to all ones. In full-duplex operation a select bit chooses whether the transmitted or the received bits feed it. In three-wire operation the transfer direction decides.

Top module: `spim_master`

## Requirements
- R1: After reset, spi_ss_n is 1, spi_sck is 0, busy is 0, fifo_level is 0, fifo_err is 0 and crc_value is 16'hFFFF.
- R2: With xfer_len = 3'b000 a transfer gives exactly 8 rising spi_sck edges. spi_mosi presents tx_data bit 7 first. The 8 bits sampled from spi_miso enter the receive queue with the first bit in bit 7.
- R3: With xfer_len = n, where n is 1 to 7, a transfer gives exactly n rising spi_sck edges. The stored entry holds the sampled bits in bits n-1..0, first bit highest, and zeros above.
- R4: In three-wire mode (cfg_three_wire = 1), a transmit transfer (xfer_rx = 0) holds spi_mosi_oe at 1 and leaves the queue unchanged. A receive transfer (xfer_rx = 1) holds spi_mosi_oe at 0 throughout and stores its bits.
- R5: busy is 1 from the cycle after an accepted xfer_start until slave select is released, and spi_sck is never 1 while busy is 0.
- R6: With cfg_auto_ss = 1, spi_ss_n falls on acceptance. The first rising spi_sck follows cfg_gap + cfg_div + 2 cycles later. spi_ss_n rises cfg_gap + 1 cycles after the last falling spi_sck. Each spi_sck half period is cfg_div + 1 cycles.
- R7: With cfg_auto_ss = 0, spi_ss_n equals the inverse of cfg_manual_ss at all times, including during transfers.
- R8: The receive queue holds 8 entries, returns them oldest first on rd_data, and each cycle with rd_en high removes one entry.
- R9: fifo_err becomes 1 when a store meets a full queue (the new entry is dropped) or when rd_en is high with an empty queue. It stays 1 until fifo_err_clr, and a new error in the same cycle as the clear wins.
- R10: A store and a read in the same cycle on a full queue leave fifo_level at 8, raise no error and keep the entry order.
- R11: In full-duplex mode cfg_crc_rx_sel = 1 feeds the CRC from the received bits and 0 from the transmitted bits. In three-wire mode cfg_crc_rx_sel is ignored and the transfer direction selects.
- R12: cfg_crc_mode selects 0: x^16+x^12+x^5+1, 1: x^16+x^15+x^2+1, 2: x^7+x^3+1 (crc_value bits 6..0, upper bits 0), 3: same as 0, shifted MSB first. crc_clear sets the register to all ones on the next cycle.
- R13: xfer_start is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_three_wire | input | 1 | Shared data pin, half-duplex transfers |
| cfg_auto_ss | input | 1 | 1: engine frames slave select; 0: manual |
| cfg_manual_ss | input | 1 | Manual slave-select level (1 = selected) |
| cfg_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| cfg_gap | input | GAP_W | Guard cycles before the first and after the last clock edge |
| cfg_crc_rx_sel | input | 1 | Full-duplex CRC source: 1 received, 0 transmitted |
| cfg_crc_mode | input | 2 | CRC polynomial select |
| crc_clear | input | 1 | Set CRC register to all ones |
| fifo_err_clr | input | 1 | Clear the queue error flag |
| xfer_start | input | 1 | Start one transfer when idle |
| xfer_rx | input | 1 | Three-wire direction: 1 receive, 0 transmit |
| xfer_len | input | 3 | Bit count: 0 means 8, else 1 to 7 |
| tx_data | input | 8 | Byte to shift out |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest queue entry |
| fifo_level | output | LVL_W | Number of queued entries |
| fifo_err | output | 1 | Sticky overflow / empty-read flag |
| busy | output | 1 | Transfer state machine active |
| crc_value | output | 16 | Current CRC |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_ss_n | output | 1 | Slave select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for the data-out pin |
| spi_miso | input | 1 | Serial data in |

## Verification
The store at the last rising serial-clock edge and a data-port read can land on the same system clock edge. On a full queue, the result decides between a correct pass-through and a false overflow. The bench provokes this with the divider at zero. It fills the queue with eight transfers, then raises rd_en in the cycle just before the final rising edge of a ninth transfer. It judges the outcome by fifo_level staying at 8, fifo_err staying low, the popped value being the oldest entry and the drained order matching its model queue.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {SP_IDLE, SP_LEAD, SP_SHIFT, SP_TRAIL} spim_state_e;

   localparam logic [1:0] CRC_CCITT = 2'd0;
   localparam logic [1:0] CRC_16    = 2'd1;
   localparam logic [1:0] CRC_7     = 2'd2;

   // One serial step of the selected polynomial, most significant bit first
   function automatic logic [15:0] crc_next(input logic [15:0] cur, input logic din,
                                            input logic [1:0] mode);
      logic        fb;
      logic [15:0] nxt;
      if (mode == CRC_7) begin
         fb  = cur[6] ^ din;
         nxt = {9'd0, cur[5:0], 1'b0} ^ (fb ? 16'h0009 : 16'h0000);
      end else begin
         fb  = cur[15] ^ din;
         nxt = {cur[14:0], 1'b0} ^ (fb ? ((mode == CRC_16) ? 16'h8005 : 16'h1021) : 16'h0000);
      end
      return nxt;
   endfunction
endpackage

// File: rtl/spim_rxfifo.sv
module spim_rxfifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic [LW-1:0]    level,
   input  logic             err_clr,
   output logic             err
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             empty, full, pop_ok, push_ok;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign pop_data = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_ok && (wr_ptr == AW'(i))) mem[i] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         err    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         level <= level + LW'(push_ok) - LW'(pop_ok);
         if ((push && !push_ok) || (pop && empty)) err <= 1'b1;
         else if (err_clr)                        err <= 1'b0;
      end
   end
endmodule

// File: rtl/spim_crc.sv
module spim_crc
   import spim_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic        din,
   input  logic [1:0]  mode,
   output logic [15:0] value
);
   logic [15:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= 16'hFFFF;
      else if (clr) crc_q <= 16'hFFFF;
      else if (en)  crc_q <= crc_next(crc_q, din, mode);
   end

   assign value = (mode == CRC_7) ? {9'd0, crc_q[6:0]} : crc_q;
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int GAP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             three_wire,
   input  logic             rx_dir,
   input  logic [2:0]       len,
   input  logic [7:0]       tx_byte,
   input  logic [DIV_W-1:0] div,
   input  logic [GAP_W-1:0] gap,
   input  logic             crc_rx_sel,
   input  logic             miso,
   output logic             sck,
   output logic             mosi,
   output logic             mosi_oe,
   output logic             active,
   output logic             crc_en,
   output logic             crc_bit,
   output logic             push,
   output logic [7:0]       push_data
);
   spim_state_e      st;
   logic [GAP_W-1:0] gcnt;
   logic [DIV_W-1:0] hcnt;
   logic             sck_q, tw_q, rxd_q;
   logic [3:0]       bleft;
   logic [7:0]       tx_sh, rx_sh;
   logic             edge_now, rise, store_en;

   assign edge_now = (st == SP_SHIFT) && (hcnt == div);
   assign rise     = edge_now && !sck_q;
   assign store_en = !tw_q || rxd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SP_IDLE;
         gcnt  <= '0;
         hcnt  <= '0;
         sck_q <= 1'b0;
         bleft <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
         tw_q  <= 1'b0;
         rxd_q <= 1'b0;
      end else begin
         case (st)
            SP_IDLE: if (start) begin
               st    <= SP_LEAD;
               gcnt  <= gap;
               hcnt  <= '0;
               sck_q <= 1'b0;
               tx_sh <= tx_byte;
               rx_sh <= '0;
               bleft <= (len == 3'd0) ? 4'd8 : {1'b0, len};
               tw_q  <= three_wire;
               rxd_q <= rx_dir;
            end
            SP_LEAD: if (gcnt == '0) st <= SP_SHIFT;
                     else            gcnt <= gcnt - 1'b1;
            SP_SHIFT: if (edge_now) begin
               hcnt  <= '0;
               sck_q <= !sck_q;
               if (!sck_q) begin
                  rx_sh <= {rx_sh[6:0], miso};
                  bleft <= bleft - 1'b1;
               end else if (bleft == 4'd0) begin
                  st   <= SP_TRAIL;
                  gcnt <= gap;
               end else begin
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end else begin
               hcnt <= hcnt + 1'b1;
            end
            SP_TRAIL: if (gcnt == '0) st <= SP_IDLE;
                      else            gcnt <= gcnt - 1'b1;
            default: st <= SP_IDLE;
         endcase
      end
   end

   assign active    = (st != SP_IDLE);
   assign sck       = sck_q;
   assign mosi      = tx_sh[7];
   assign mosi_oe   = active ? !(tw_q && rxd_q) : !three_wire;
   assign crc_en    = rise;
   assign crc_bit   = (tw_q ? rxd_q : crc_rx_sel) ? miso : tx_sh[7];
   assign push      = rise && (bleft == 4'd1) && store_en;
   assign push_data = {rx_sh[6:0], miso};
endmodule

// File: rtl/spim_master.sv
module spim_master #(
   parameter int DIV_W      = 4,
   parameter int GAP_W      = 4,
   parameter int FIFO_DEPTH = 8,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_three_wire,
   input  logic             cfg_auto_ss,
   input  logic             cfg_manual_ss,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cfg_crc_rx_sel,
   input  logic [1:0]       cfg_crc_mode,
   input  logic             crc_clear,
   input  logic             fifo_err_clr,
   input  logic             xfer_start,
   input  logic             xfer_rx,
   input  logic [2:0]       xfer_len,
   input  logic [7:0]       tx_data,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic [LVL_W-1:0] fifo_level,
   output logic             fifo_err,
   output logic             busy,
   output logic [15:0]      crc_value,
   output logic             spi_sck,
   output logic             spi_ss_n,
   output logic             spi_mosi,
   output logic             spi_mosi_oe,
   input  logic             spi_miso
);
   if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
      $error("spim_master: DIV_W out of range");
   end
   if (GAP_W < 1 || GAP_W > 12) begin : g_bad_gap
      $error("spim_master: GAP_W out of range");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_master: FIFO_DEPTH must be a power of two of at least 2");
   end

   logic       crc_en, crc_bit, push;
   logic [7:0] push_data;

   spim_shifter #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(xfer_start), .three_wire(cfg_three_wire),
      .rx_dir(xfer_rx), .len(xfer_len), .tx_byte(tx_data), .div(cfg_div), .gap(cfg_gap),
      .crc_rx_sel(cfg_crc_rx_sel), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
      .mosi_oe(spi_mosi_oe), .active(busy), .crc_en(crc_en), .crc_bit(crc_bit),
      .push(push), .push_data(push_data)
   );

   spim_rxfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(rd_en),
      .pop_data(rd_data), .level(fifo_level), .err_clr(fifo_err_clr), .err(fifo_err)
   );

   spim_crc u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clear), .en(crc_en), .din(crc_bit),
      .mode(cfg_crc_mode), .value(crc_value)
   );

   assign spi_ss_n = cfg_auto_ss ? !busy : !cfg_manual_ss;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk #(
   parameter int FIFO_DEPTH = 8,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_three_wire,
   input logic             cfg_auto_ss,
   input logic             cfg_manual_ss,
   input logic [1:0]       cfg_crc_mode,
   input logic             crc_clear,
   input logic             rd_en,
   input logic [LVL_W-1:0] fifo_level,
   input logic             fifo_err,
   input logic             busy,
   input logic [15:0]      crc_value,
   input logic             spi_sck,
   input logic             spi_ss_n,
   input logic             spi_mosi_oe
);
   // R5
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> busy);
   // R5
   ss_released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_auto_ss) |-> spi_ss_n);
   // R7
   manual_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_auto_ss |-> (spi_ss_n == !cfg_manual_ss));
   // R4
   half_tx_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_three_wire && busy && spi_mosi_oe) |=> (fifo_level <= $past(fifo_level)));
   // R8
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH));
   // R9
   empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fifo_level == '0) |=> fifo_err);
   // R12
   crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_clear && $stable(cfg_crc_mode)) |=>
      (crc_value == ((cfg_crc_mode == 2'd2) ? 16'h007F : 16'hFFFF)));
endmodule

bind spim_master spim_master_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/sim_spim_master.sv
`timescale 1ns/1ps
module sim_spim_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_three_wire = 1'b0, cfg_auto_ss = 1'b1, cfg_manual_ss = 1'b0;
   logic [3:0] cfg_div = 4'd1, cfg_gap = 4'd2;
   logic       cfg_crc_rx_sel = 1'b0;
   logic [1:0] cfg_crc_mode = 2'd0;
   logic       crc_clear = 1'b0, fifo_err_clr = 1'b0, xfer_start = 1'b0, xfer_rx = 1'b0;
   logic [2:0] xfer_len = 3'd0;
   logic [7:0] tx_data = 8'd0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] fifo_level;
   logic       fifo_err, busy, spi_sck, spi_ss_n, spi_mosi, spi_mosi_oe, spi_miso;
   logic [15:0] crc_value;

   spim_master u0 (.*);

   always #2.5 clk = ~clk;

   // slave model: shifts slave_byte MSB first, advancing after each falling sck
   logic [7:0] slave_byte = 8'd0;
   int         slv_idx = 0;
   logic [7:0] cap = 8'd0;
   logic       slave_bit;
   assign slave_bit = (slv_idx < 8) ? slave_byte[3'(7 - slv_idx)] : 1'b0;
   assign spi_miso  = (cfg_three_wire && spi_mosi_oe) ? spi_mosi : slave_bit;
   always @(negedge spi_sck) slv_idx = slv_idx + 1;
   always @(posedge spi_sck) cap = {cap[6:0], spi_mosi};

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [7:0]  mq[$];
   logic        merr = 1'b0;
   logic [15:0] mcrc = 16'hFFFF;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b,
                                           input logic [1:0] m);
      logic [15:0] poly;
      int          top;
      top  = (m == 2'd2) ? 6 : 15;
      poly = (m == 2'd1) ? 16'h8005 : (m == 2'd2) ? 16'h0009 : 16'h1021;
      if (c[top] ^ b) c = (c << 1) ^ poly;
      else            c = c << 1;
      if (m == 2'd2) c = c & 16'h007F;
      return c;
   endfunction

   function automatic logic [15:0] crc_view(input logic [15:0] c, input logic [1:0] m);
      return (m == 2'd2) ? (c & 16'h007F) : c;
   endfunction

   logic [7:0] popped;

   task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic [2:0] len,
                       input bit rxd, input bit pop_push, input bit restart);
      int  n, cyc, rises, first_rise, last_fall, ss_low, ss_high;
      bit  prev_sck, oe_bad, ss_bad, pop_done, tw, store, src_rx;
      logic [7:0] rbits, sbits;
      n = (len == 3'd0) ? 8 : int'(len);
      tw = cfg_three_wire;
      slave_byte = sl;
      slv_idx = 0;
      cap = 8'd0;
      @(negedge clk);
      tx_data = tx; xfer_len = len; xfer_rx = rxd; xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      chk(busy == 1'b1, "R5", "busy after start", busy, 1);
      cyc = 0; rises = 0; prev_sck = 0; first_rise = -1; last_fall = -1;
      ss_low = -1; ss_high = -1; oe_bad = 0; ss_bad = 0; pop_done = 0;
      while (1) begin
         if (!spi_ss_n && ss_low < 0) ss_low = cyc;
         if (spi_sck && !prev_sck) begin
            rises++;
            if (first_rise < 0) first_rise = cyc;
         end
         if (!spi_sck && prev_sck) last_fall = cyc;
         prev_sck = spi_sck;
         if (busy && tw && (spi_mosi_oe != !rxd)) oe_bad = 1;
         if (!cfg_auto_ss && (spi_ss_n != !cfg_manual_ss)) ss_bad = 1;
         rd_en = 1'b0;
         if (pop_push && !pop_done && rises == n - 1 && !spi_sck && first_rise >= 0) begin
            popped = rd_data;
            rd_en = 1'b1;
            pop_done = 1;
         end
         xfer_start = (restart && cyc == 3);
         if (!busy) begin
            ss_high = cyc;
            break;
         end
         if (cyc > 5000) break;
         @(negedge clk);
         cyc++;
      end
      xfer_start = 1'b0;
      rd_en = 1'b0;
      chk(rises == n, (len == 3'd0) ? "R2" : "R3", "sck pulse count", rises, n);
      if (cfg_auto_ss) begin
         chk(first_rise - ss_low == int'(cfg_gap) + int'(cfg_div) + 2, "R6", "lead time",
             first_rise - ss_low, int'(cfg_gap) + int'(cfg_div) + 2);
         chk(ss_high - last_fall == int'(cfg_gap) + 1, "R6", "trail time",
             ss_high - last_fall, int'(cfg_gap) + 1);
      end else begin
         chk(!ss_bad, "R7", "manual select held", ss_bad, 0);
      end
      if (!(tw && rxd))
         chk((cap & 8'((1 << n) - 1)) == (tx >> (8 - n)), "R2", "mosi bits",
             cap & 8'((1 << n) - 1), tx >> (8 - n));
      if (tw) chk(!oe_bad, "R4", "output enable follows direction", oe_bad, 0);
      // model update
      sbits = sl >> (8 - n);
      rbits = (tw && !rxd) ? (tx >> (8 - n)) : sbits;
      store = !tw || rxd;
      if (pop_push) begin
         chk(popped == mq[0], "R10", "value read during store", popped, mq[0]);
         void'(mq.pop_front());
      end
      if (store) begin
         if (mq.size() < 8) mq.push_back(rbits);
         else merr = 1'b1;
      end
      src_rx = tw ? rxd : cfg_crc_rx_sel;
      for (int i = n - 1; i >= 0; i--)
         mcrc = crc_upd(mcrc, src_rx ? rbits[i] : tx[3'(8 - n + i)], cfg_crc_mode);
      chk(crc_value == crc_view(mcrc, cfg_crc_mode), tw ? "R11" : "R12", "crc value",
          crc_value, crc_view(mcrc, cfg_crc_mode));
   endtask

   task automatic drain(input string req);
      chk(int'(fifo_level) == mq.size(), req, "queue level", fifo_level, mq.size());
      while (fifo_level != 4'd0) begin
         chk(rd_data == mq[0], req, "queue data", rd_data, mq[0]);
         void'(mq.pop_front());
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
   endtask

   task automatic clear_crc();
      @(negedge clk);
      crc_clear = 1'b1;
      @(negedge clk);
      crc_clear = 1'b0;
      mcrc = 16'hFFFF;
      chk(crc_value == crc_view(16'hFFFF, cfg_crc_mode), "R12", "crc after clear",
          crc_value, crc_view(16'hFFFF, cfg_crc_mode));
   endtask

   task automatic clear_err();
      @(negedge clk);
      fifo_err_clr = 1'b1;
      @(negedge clk);
      fifo_err_clr = 1'b0;
      merr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(spi_ss_n == 1'b1 && spi_sck == 1'b0, "R1", "select/clock at reset",
          {spi_ss_n, spi_sck}, 2'b10);
      chk(busy == 1'b0 && fifo_level == 4'd0 && fifo_err == 1'b0, "R1", "status at reset",
          {busy, fifo_level, fifo_err}, 0);
      chk(crc_value == 16'hFFFF, "R1", "crc at reset", crc_value, 16'hFFFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 full byte, R11 full-duplex crc from transmit
      xfer(8'hA5, 8'h3C, 3'd0, 1'b0, 1'b0, 1'b0);
      drain("R2");
      cfg_crc_rx_sel = 1'b1;
      xfer(8'h0F, 8'hC6, 3'd0, 1'b0, 1'b0, 1'b0);
      drain("R11");

      // R3 partial lengths
      for (int k = 1; k < 8; k++) begin
         xfer(8'($urandom), 8'($urandom), 3'(k), 1'b0, 1'b0, 1'b0);
      end
      drain("R3");

      // R12 each polynomial, random full-duplex traffic
      for (int m = 0; m < 4; m++) begin
         cfg_crc_mode = 2'(m);
         clear_crc();
         for (int t = 0; t < 6; t++) begin
            cfg_div = 4'($urandom % 4);
            cfg_gap = 4'($urandom % 6);
            cfg_crc_rx_sel = 1'($urandom);
            xfer(8'($urandom), 8'($urandom), 3'($urandom), 1'b0, 1'b0, 1'b0);
            drain("R8");
         end
      end

      // R4 and R11 three-wire
      cfg_three_wire = 1'b1;
      cfg_crc_mode = 2'd0;
      cfg_crc_rx_sel = 1'b1;
      xfer(8'h96, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
      chk(fifo_level == 4'd0, "R4", "transmit-only stores nothing", fifo_level, 0);
      cfg_crc_rx_sel = 1'b0;
      xfer(8'hFF, 8'h5B, 3'd0, 1'b1, 1'b0, 1'b0);
      xfer(8'h00, 8'hE4, 3'd5, 1'b1, 1'b0, 1'b0);
      drain("R4");
      cfg_three_wire = 1'b0;

      // R7 manual select
      cfg_auto_ss = 1'b0;
      cfg_manual_ss = 1'b1;
      @(negedge clk);
      chk(spi_ss_n == 1'b0, "R7", "manual select asserted", spi_ss_n, 0);
      xfer(8'h3A, 8'h71, 3'd0, 1'b0, 1'b0, 1'b0);
      cfg_manual_ss = 1'b0;
      @(negedge clk);
      chk(spi_ss_n == 1'b1, "R7", "manual select released", spi_ss_n, 1);
      xfer(8'h11, 8'h22, 3'd3, 1'b0, 1'b0, 1'b0);
      drain("R7");
      cfg_auto_ss = 1'b1;

      // R13 start while busy
      xfer(8'hC3, 8'h81, 3'd0, 1'b0, 1'b0, 1'b1);
      repeat (30) @(negedge clk);
      chk(busy == 1'b0, "R13", "no second transfer", busy, 0);
      chk(int'(fifo_level) == mq.size(), "R13", "one entry only", fifo_level, mq.size());
      drain("R13");

      // R9 overflow and empty read
      for (int k = 0; k < 9; k++) xfer(8'($urandom), 8'($urandom), 3'd0, 1'b0, 1'b0, 1'b0);
      chk(fifo_level == 4'd8, "R9", "level at overflow", fifo_level, 8);
      chk(fifo_err == merr, "R9", "overflow flag", fifo_err, merr);
      drain("R9");
      chk(fifo_err == 1'b1, "R9", "flag sticky", fifo_err, 1);
      clear_err();
      chk(fifo_err == 1'b0, "R9", "flag cleared", fifo_err, 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(fifo_err == 1'b1, "R9", "empty read flag", fifo_err, 1);
      chk(fifo_level == 4'd0, "R9", "empty read level", fifo_level, 0);
      clear_err();

      // R10 store and read in the same cycle on a full queue
      cfg_div = 4'd0;
      cfg_gap = 4'd1;
      for (int k = 0; k < 8; k++) xfer(8'($urandom), 8'($urandom), 3'd0, 1'b0, 1'b0, 1'b0);
      xfer(8'h5E, 8'hB7, 3'd0, 1'b0, 1'b1, 1'b0);
      chk(fifo_level == 4'd8, "R10", "level kept", fifo_level, 8);
      chk(fifo_err == 1'b0, "R10", "no false overflow", fifo_err, 0);
      drain("R10");

      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule